// File: doc/BRIEF.md
# Paged Memory Decoder with Switch Write Inhibit

This block sits between a processor with a 16-bit address bus and a bank of three memory sockets, using an 8-bit page value to stretch the reachable space to 24 bits. The lower half of the processor space (address bit 15 clear) is a 32 KB window whose contents depend on the page value. The upper half is a fixed window that is the same whatever the page. From the page, the address and a few configuration inputs, the block produces one active-low chip select for each socket: a kernel ROM, a main RAM and a socket that can hold either RAM or ROM. It also produces bus-cycle strobes for output enable and write enable, both qualified by the E clock.

Two protect switches turn page pairs of the RAM/ROM socket into read-only memory by suppressing the write strobe. A RAM/ROM mode input does the same for the whole socket when a programmed ROM is fitted. A size input tells the decoder whether the main RAM is a small or a large part. The block is purely combinational and holds no state.

Top module: `paged_mem_decoder`

## Requirements
- R1: When `addr_i[15]` is 1 (common access), every output is independent of `page_i`.
- R2: `rr_cs_n_o` is 0 exactly when `addr_i[15]` is 0 and `page_i` is 4, 5, 6 or 7. While it is 0, `rr_bank_o` equals `page_i[1:0]`; otherwise `rr_bank_o` is 0.
- R3: With `wp_lo_i` = 1, `we_n_o` stays 1 for any access that selects the RAM/ROM socket on page 4 or 5. `oe_n_o` is unaffected.
- R4: With `wp_hi_i` = 1, `we_n_o` stays 1 for any access that selects the RAM/ROM socket on page 6 or 7. `oe_n_o` is unaffected.
- R5: With `rom_mode_i` = 1, `we_n_o` stays 1 for every access that selects the RAM/ROM socket, whatever the protect inputs are.
- R6: `ram_cs_n_o` is 0 for paged accesses on page 15 at offsets 3000h–7FFFh and for common addresses 8100h–ADFFh, with either RAM size. On page 15 below 3000h it is 1.
- R7: With `ram_128k_i` = 1, `ram_cs_n_o` is also 0 for paged accesses on pages 1, 2 and 3. With `ram_128k_i` = 0 it is 1 there.
- R8: A write that selects the main RAM always gets `we_n_o` = 0 while `eclk_i` is 1, with all protect and mode inputs set.
- R9: `oe_n_o` is 0 exactly when `eclk_i` = 1 and `rd_nwr_i` = 1 (read).
- R10: `we_n_o` is 0 exactly when `eclk_i` = 1, `rd_nwr_i` = 0 and the access is not inhibited by R3, R4 or R5.
- R11: For common addresses C000h–C07Fh (reserved for user peripherals) all three selects are 1.
- R12: At most one of the three selects is 0 at any time.
- R13: `kern_cs_n_o` is 0 exactly for paged accesses on pages 0, 12, 13 and 14 and for common addresses C100h–FFFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| page_i | input | 8 | Page value, upper 8 bits of the extended address |
| addr_i | input | 16 | Processor address |
| rd_nwr_i | input | 1 | 1 for read, 0 for write |
| eclk_i | input | 1 | Bus E clock; high while address and data are valid |
| ram_128k_i | input | 1 | 1 when the main RAM socket holds a 128 KB part |
| wp_lo_i | input | 1 | Write-protect pages 4 and 5 of the RAM/ROM socket |
| wp_hi_i | input | 1 | Write-protect pages 6 and 7 of the RAM/ROM socket |
| rom_mode_i | input | 1 | RAM/ROM socket holds a ROM; never write it |
| kern_cs_n_o | output | 1 | Kernel ROM select, active low |
| ram_cs_n_o | output | 1 | Main RAM select, active low |
| rr_cs_n_o | output | 1 | RAM/ROM socket select, active low |
| rr_bank_o | output | 2 | Upper address lines for the RAM/ROM socket |
| oe_n_o | output | 1 | Output enable strobe, active low |
| we_n_o | output | 1 | Write enable strobe, active low |

## Verification
The block holds no state, so a wrong decode shows at the select pins on the same cycle as the input vector. No fault can hide for later. A bad window boundary appears as a wrong select at the neighbouring address value. A bad inhibit term appears as a write strobe on a protected page, or as a missing strobe on an open one. The bench therefore aims its vectors at every window edge, at every page in each mode, and at every switch combination under write cycles.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int PAGE_W = 8;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = ADDR_W - 1;

  typedef struct packed {
    logic              paged;
    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;
  } xaddr_t;

  typedef struct packed {
    logic kern;
    logic ram;
    logic rr;
  } sel_t;
endpackage

// File: rtl/pmd_addr_split.sv
module pmd_addr_split
  import pmd_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  output xaddr_t            xa_o
);
  always_comb begin
    xa_o.paged = ~addr_i[ADDR_W-1];
    xa_o.page  = page_i;
    xa_o.ofs   = addr_i[OFS_W-1:0];
  end
endmodule

// File: rtl/pmd_select.sv
module pmd_select
  import pmd_pkg::*;
#(
  parameter logic [PAGE_W-1:0] RR_BASE_PAGE   = 8'd4,
  parameter logic [PAGE_W-1:0] RAM_HI_PAGE    = 8'd15,
  parameter logic [OFS_W-1:0]  RAM_HI_OFS_LO  = 15'h3000,
  parameter logic [PAGE_W-1:0] RAM_BANK_FIRST = 8'd1,
  parameter logic [PAGE_W-1:0] RAM_BANK_LAST  = 8'd3,
  parameter logic [ADDR_W-1:0] RAM_COM_LO     = 16'h8100,
  parameter logic [ADDR_W-1:0] RAM_COM_HI     = 16'hADFF,
  parameter logic [ADDR_W-1:0] USR_LO         = 16'hC000,
  parameter logic [ADDR_W-1:0] USR_HI         = 16'hC07F,
  parameter logic [ADDR_W-1:0] KERN_COM_LO    = 16'hC100,
  parameter logic [PAGE_W-1:0] KERN_LO_PAGE   = 8'd0,
  parameter logic [PAGE_W-1:0] KERN_HI_FIRST  = 8'd12,
  parameter logic [PAGE_W-1:0] KERN_HI_LAST   = 8'd14
)(
  input  xaddr_t     xa_i,
  input  logic       ram_128k_i,
  output sel_t       sel_o,
  output logic [1:0] rr_bank_o
);
  localparam int RR_PAGES = 4;
  localparam int RR_SEL_W = $clog2(RR_PAGES);

  logic [ADDR_W-1:0] full_addr;
  logic rr_hit, ram_hi_hit, ram_bank_hit, ram_com_hit;
  logic kern_pg_hit, kern_com_hit, user_hole;

  always_comb begin
    full_addr    = {~xa_i.paged, xa_i.ofs};
    rr_hit       = xa_i.paged &&
                   (xa_i.page[PAGE_W-1:RR_SEL_W] == RR_BASE_PAGE[PAGE_W-1:RR_SEL_W]);
    ram_hi_hit   = xa_i.paged && (xa_i.page == RAM_HI_PAGE) &&
                   (xa_i.ofs >= RAM_HI_OFS_LO);
    ram_bank_hit = xa_i.paged && ram_128k_i &&
                   (xa_i.page >= RAM_BANK_FIRST) && (xa_i.page <= RAM_BANK_LAST);
    ram_com_hit  = !xa_i.paged && (full_addr >= RAM_COM_LO) &&
                   (full_addr <= RAM_COM_HI);
    kern_pg_hit  = xa_i.paged && ((xa_i.page == KERN_LO_PAGE) ||
                   ((xa_i.page >= KERN_HI_FIRST) && (xa_i.page <= KERN_HI_LAST)));
    kern_com_hit = !xa_i.paged && (full_addr >= KERN_COM_LO);
    user_hole    = !xa_i.paged && (full_addr >= USR_LO) && (full_addr <= USR_HI);

    sel_o.rr   = rr_hit;
    sel_o.ram  = ram_hi_hit | ram_bank_hit | ram_com_hit;
    sel_o.kern = kern_pg_hit | kern_com_hit;
    rr_bank_o  = rr_hit ? xa_i.page[RR_SEL_W-1:0] : '0;
  end

  // R12: windows never overlap
  always_comb begin
    a_r12_one_select: assert ($countones(sel_o) <= 1)
      else $error("more than one memory select active");
  end

  // R11: reserved peripheral hole stays free of memory selects
  always_comb begin
    if (user_hole)
      a_r11_user_hole_free: assert (sel_o == '0)
        else $error("memory select inside reserved peripheral window");
  end
endmodule

// File: rtl/pmd_strobe.sv
module pmd_strobe
  import pmd_pkg::*;
(
  input  logic       eclk_i,
  input  logic       rd_nwr_i,
  input  sel_t       sel_i,
  input  logic [1:0] rr_bank_i,
  input  logic       wp_lo_i,
  input  logic       wp_hi_i,
  input  logic       rom_mode_i,
  output logic       oe_n_o,
  output logic       we_n_o
);
  logic inhibit;

  always_comb begin
    inhibit = sel_i.rr & (rom_mode_i |
                          (wp_lo_i & ~rr_bank_i[1]) |
                          (wp_hi_i &  rr_bank_i[1]));
    oe_n_o  = ~(eclk_i & rd_nwr_i);
    we_n_o  = ~(eclk_i & ~rd_nwr_i & ~inhibit);
  end

  // R5: a ROM-mode socket never sees a write strobe
  always_comb begin
    if (sel_i.rr && rom_mode_i)
      a_r5_rom_never_written: assert (we_n_o)
        else $error("write strobe reached ROM-mode socket");
  end

  // R8: main RAM writes are never inhibited
  always_comb begin
    if (sel_i.ram && eclk_i && !rd_nwr_i)
      a_r8_ram_unprotected: assert (!we_n_o)
        else $error("main RAM write strobe suppressed");
  end

  // R9/R10: the two strobes are never active together
  always_comb begin
    a_r10_strobes_exclusive: assert (oe_n_o || we_n_o)
      else $error("read and write strobes both active");
  end
endmodule

// File: rtl/paged_mem_decoder.sv
module paged_mem_decoder
  import pmd_pkg::*;
(
  input  logic [7:0]  page_i,
  input  logic [15:0] addr_i,
  input  logic        rd_nwr_i,
  input  logic        eclk_i,
  input  logic        ram_128k_i,
  input  logic        wp_lo_i,
  input  logic        wp_hi_i,
  input  logic        rom_mode_i,
  output logic        kern_cs_n_o,
  output logic        ram_cs_n_o,
  output logic        rr_cs_n_o,
  output logic [1:0]  rr_bank_o,
  output logic        oe_n_o,
  output logic        we_n_o
);
  xaddr_t     xa;
  sel_t       sel;
  logic [1:0] bank;

  pmd_addr_split u_split (
    .page_i (page_i),
    .addr_i (addr_i),
    .xa_o   (xa)
  );

  pmd_select u_select (
    .xa_i       (xa),
    .ram_128k_i (ram_128k_i),
    .sel_o      (sel),
    .rr_bank_o  (bank)
  );

  pmd_strobe u_strobe (
    .eclk_i     (eclk_i),
    .rd_nwr_i   (rd_nwr_i),
    .sel_i      (sel),
    .rr_bank_i  (bank),
    .wp_lo_i    (wp_lo_i),
    .wp_hi_i    (wp_hi_i),
    .rom_mode_i (rom_mode_i),
    .oe_n_o     (oe_n_o),
    .we_n_o     (we_n_o)
  );

  always_comb begin
    kern_cs_n_o = ~sel.kern;
    ram_cs_n_o  = ~sel.ram;
    rr_cs_n_o   = ~sel.rr;
    rr_bank_o   = bank;
  end

  // R2: bank lines only move while the RAM/ROM socket is selected
  always_comb begin
    if (rr_cs_n_o)
      a_r2_bank_idle: assert (rr_bank_o == 2'b00)
        else $error("bank lines active without socket select");
  end
endmodule

// File: tb/paged_mem_decoder_tb.sv
module paged_mem_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  page;
  logic [15:0] addr;
  logic rd, e, big, wl, wh, rm;
  logic kern_n, ram_n, rr_n, oe_n, we_n;
  logic [1:0] bank;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  paged_mem_decoder u_dut (
    .page_i(page), .addr_i(addr), .rd_nwr_i(rd), .eclk_i(e),
    .ram_128k_i(big), .wp_lo_i(wl), .wp_hi_i(wh), .rom_mode_i(rm),
    .kern_cs_n_o(kern_n), .ram_cs_n_o(ram_n), .rr_cs_n_o(rr_n),
    .rr_bank_o(bank), .oe_n_o(oe_n), .we_n_o(we_n)
  );

  // Behavioural expectation: {kern_n, ram_n, rr_n, bank[1:0], oe_n, we_n}
  function automatic logic [6:0] model(int pg, int ad, bit r, bit ec,
                                       bit b, bit lo, bit hi, bit rom);
    bit k = 0, m = 0, s = 0, inh, o, w;
    int bk = 0;
    if (ad < 32768) begin
      s = (pg >= 4) && (pg <= 7);
      m = (pg == 15 && ad >= 12288) || (b && pg >= 1 && pg <= 3);
      k = (pg == 0) || (pg >= 12 && pg <= 14);
    end else begin
      m = (ad >= 33024) && (ad <= 44543);
      k = (ad >= 49408);
    end
    if (s) bk = pg % 4;
    inh = s && (rom || (lo && pg <= 5) || (hi && pg >= 6));
    o = !(ec && r);
    w = !(ec && !r && !inh);
    return {!k, !m, !s, 2'(bk), o, w};
  endfunction

  task automatic apply(input int pg, input int ad, input bit r, input bit ec,
                       input bit b, input bit lo, input bit hi, input bit rom,
                       input string req);
    logic [6:0] exp, got;
    @(posedge clk);
    #1;
    page = 8'(pg); addr = 16'(ad); rd = r; e = ec;
    big = b; wl = lo; wh = hi; rm = rom;
    @(negedge clk);
    exp = model(pg, ad, r, ec, b, lo, hi, rom);
    got = {kern_n, ram_n, rr_n, bank, oe_n, we_n};
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s page=%0h addr=%0h rd=%0b e=%0b sw=%0b%0b%0b%0b got=%b exp=%b",
               req, pg, ad, r, ec, b, lo, hi, rom, got, exp);
    end
    if ($countones({~kern_n, ~ram_n, ~rr_n}) > 1) begin
      bad++;
      $display("FAIL R12 multiple selects got=%b exp=at most one low",
               {kern_n, ram_n, rr_n});
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    page = '0; addr = '0; rd = 1'b1; e = 1'b0;
    big = 1'b0; wl = 1'b0; wh = 1'b0; rm = 1'b0;

    // Idle bus: strobes inactive (R9, R10)
    apply(0, 16'h0000, 1, 0, 0, 0, 0, 0, "R9 idle");
    apply(4, 16'h1000, 0, 0, 0, 0, 0, 0, "R10 idle");

    // R2 bank lines across the socket pages
    for (int p = 4; p < 8; p++) apply(p, 16'h7FFF, 1, 1, 0, 0, 0, 0, "R2");

    // R3 / R4 protect pairs, writes and reads
    for (int p = 4; p < 8; p++) begin
      apply(p, 16'h2000, 0, 1, 0, 1, 0, 0, "R3");
      apply(p, 16'h2000, 0, 1, 0, 0, 1, 0, "R4");
      apply(p, 16'h2000, 1, 1, 0, 1, 1, 0, "R3 R4 read");
      apply(p, 16'h2000, 0, 1, 0, 0, 0, 1, "R5");
      apply(p, 16'h2000, 0, 1, 0, 0, 0, 0, "R10 open");
    end

    // R6 small RAM windows and edges
    apply(15, 16'h2FFF, 0, 1, 0, 1, 1, 1, "R6 below");
    apply(15, 16'h3000, 0, 1, 0, 1, 1, 1, "R6 edge");
    apply(15, 16'h7FFF, 0, 1, 1, 1, 1, 1, "R6 top");
    apply(0, 16'h80FF, 1, 1, 0, 0, 0, 0, "R6 com below");
    apply(0, 16'h8100, 0, 1, 0, 1, 1, 1, "R8 com low");
    apply(0, 16'hADFF, 0, 1, 1, 1, 1, 1, "R8 com high");
    apply(0, 16'hAE00, 1, 1, 0, 0, 0, 0, "R6 com above");

    // R7 large RAM pages
    for (int p = 0; p < 5; p++) begin
      apply(p, 16'h4000, 0, 1, 1, 1, 1, 1, "R7 big");
      apply(p, 16'h4000, 1, 1, 0, 0, 0, 0, "R7 small");
    end

    // R11 reserved hole, R13 kernel edges
    apply(7, 16'hBFFF, 1, 1, 0, 0, 0, 0, "R11 below");
    apply(7, 16'hC000, 1, 1, 1, 0, 0, 0, "R11 low");
    apply(7, 16'hC07F, 0, 1, 1, 0, 0, 0, "R11 high");
    apply(7, 16'hC0FF, 1, 1, 0, 0, 0, 0, "R13 gap");
    apply(7, 16'hC100, 1, 1, 0, 0, 0, 0, "R13 com");
    apply(7, 16'hFFFF, 1, 1, 0, 0, 0, 0, "R13 top");

    // R1 page independence of common space
    for (int p = 0; p < 256; p += 17) begin
      apply(p, 16'h8100, 0, 1, 1, 1, 1, 1, "R1");
      apply(p, 16'hC040, 1, 1, 0, 0, 0, 0, "R1");
      apply(p, 16'hE000, 1, 1, 0, 0, 0, 0, "R1");
    end

    // Full page sweep (R2, R6, R7, R13)
    for (int p = 0; p < 256; p++) begin
      apply(p, 16'h0000, 1, 1, p[0], 0, 0, 0, "R13 sweep");
      apply(p, 16'h3000, 0, 1, p[1], p[2], p[3], 0, "R2 sweep");
      apply(p, 16'h7FFF, 0, 1, 1, 0, 0, p[4], "R7 sweep");
    end

    // Mixed stimulus, every output compared (R9, R10, R12)
    for (int i = 0; i < 20000; i++) begin
      int a;
      a = (i % 3 == 0) ? int'($urandom_range(16'hC0FF, 16'hBFF0))
                       : int'($urandom_range(65535, 0));
      apply(int'($urandom_range(255, 0)), a, $urandom_range(1, 0) == 1,
            $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
            $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
            $urandom_range(1, 0) == 1, "R12 mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule